// File: doc/BRIEF.md
# Seven-Slot Pixel Lane Serializer

This block turns parallel pixel words into bit-serial lane streams for a low-voltage differential display link. It runs on a fast bit clock that is seven times the pixel rate. A one-cycle pixel strobe marks each pixel period. On that cycle the block captures one 24-bit RGB pixel and the three video controls (data enable, horizontal sync, vertical sync). It spreads them across four data lanes, seven bit slots per lane, and shifts the slots out one per bit-clock cycle with slot 0 first.

When the dual-pixel mode is on, a second pixel goes out on four more lanes in the same way. A separate clock lane sends a fixed high-then-low pattern each pixel period. Its rising edge lines up with slot 0 of the data lanes, so a receiver can recover the pixel framing from it.

A power-down input clears every lane within one cycle and blocks new loads while it is held. The PLL that makes the bit clock, the analog drivers, pre-emphasis and DC-balance coding are all outside this block.

Top module: `pixel_lane_serializer`

## Requirements
- R1: While reset is asserted and after it is released, all data lanes and the clock lane are low until a word is loaded.
- R2: On the bit-clock edge where `pix_stb` is high (and power-down is low), a new word is captured. Slot 0 appears on the lanes right after that edge, and slot s appears s edges later, for s from 0 to 6.
- R3: Lane 0 slot s carries red bit s (`pix_in[16+s]`), lane 1 slot s carries green bit s (`pix_in[8+s]`), and lane 2 slot s carries blue bit s (`pix_in[s]`), for s from 0 to 6.
- R4: Lane 3 slots 0, 1 and 2 carry the top bits of red, green and blue (`pix_in[23]`, `pix_in[15]`, `pix_in[7]`). Slots 3, 4 and 5 carry `ctl_in[0]` (data enable), `ctl_in[1]` (horizontal sync) and `ctl_in[2]` (vertical sync). Slot 6 is always 0.
- R5: The clock lane outputs 1,1,1,1,0,0,0 over slots 0 to 6 of every loaded word. With back-to-back words it rises exactly at slot 0.
- R6: A word loaded while `dual_en` is 1 puts the second pixel (`pix_in[47:24]`) on lanes 4 to 7, using the R3/R4 mapping and the same controls.
- R7: A word loaded while `dual_en` is 0 keeps lanes 4 to 7 low for all seven slots.
- R8: If no new strobe arrives, every lane and the clock lane is low from the seventh edge after the load.
- R9: One edge after `pwr_dn` is seen high, all lanes and the clock lane are low. Strobes while `pwr_dn` is high are ignored.
- R10: A strobe that arrives before the current word has finished replaces it: slot 0 of the new word appears after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_stb | input | 1 | Pixel-period strobe; loads a new word |
| dual_en | input | 1 | Enables the second pixel on lanes 4 to 7 |
| pwr_dn | input | 1 | Clears all lanes and blocks loads |
| pix_in | input | 48 | Pixel A in bits 23:0, pixel B in bits 47:24, each {R,G,B} with 8 bits per channel |
| ctl_in | input | 3 | {VSYNC, HSYNC, DE} |
| lane_q | output | 8 | Serial data lanes, lane n on bit n |
| clk_lane | output | 1 | Forwarded clock pattern lane |

## Verification
The bench sends a table of pixel and control words back to back.

- Walking-ones and alternating colour values show whether each colour bit lands in its own lane and slot. This separates a red/green/blue swap from a slot reversal.
- Control patterns with exactly one control bit set show whether data enable, horizontal sync and vertical sync reach their own lane-3 slots, and whether the spare slot stays 0.
- Vectors with dual mode off and on, carrying distinct second pixels, separate second-pixel routing from upper-lane gating.

Directed sequences then cover three cases: draining with no strobe, a strobe in the middle of a word, and power-down with a strobe held during it.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int SLOTS  = 7;
  localparam int CH_W   = 8;
  localparam int PIX_W  = 3 * CH_W;
  localparam int LANES  = 4;
  localparam int CTL_W  = 3;
  localparam int WORD_W = LANES * SLOTS;
  localparam int CNT_W  = $clog2(SLOTS);

  typedef logic [SLOTS-1:0] slot_vec_t;

  // Lane-major packing: bit (lane*SLOTS + slot).
  function automatic logic [WORD_W-1:0] map_pixel(
    input logic [PIX_W-1:0] pix,
    input logic [CTL_W-1:0] ctl
  );
    logic [WORD_W-1:0] w;
    w = '0;
    for (int s = 0; s < SLOTS; s++) begin
      w[0*SLOTS + s] = pix[2*CH_W + s];
      w[1*SLOTS + s] = pix[1*CH_W + s];
      w[2*SLOTS + s] = pix[s];
    end
    w[3*SLOTS + 0] = pix[3*CH_W - 1];
    w[3*SLOTS + 1] = pix[2*CH_W - 1];
    w[3*SLOTS + 2] = pix[CH_W - 1];
    w[3*SLOTS + 3] = ctl[0];
    w[3*SLOTS + 4] = ctl[1];
    w[3*SLOTS + 5] = ctl[2];
    w[3*SLOTS + 6] = 1'b0;
    return w;
  endfunction

  // High for the first half (rounded up) of the slots, then low.
  function automatic slot_vec_t clk_pattern();
    slot_vec_t p;
    for (int s = 0; s < SLOTS; s++) p[s] = (s < (SLOTS + 1) / 2);
    return p;
  endfunction
endpackage

// File: rtl/pls_lane_mapper.sv
module pls_lane_mapper
  import pls_pkg::*;
(
  input  logic              grp_en,
  input  logic [PIX_W-1:0]  pix,
  input  logic [CTL_W-1:0]  ctl,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word = grp_en ? map_pixel(pix, ctl) : '0;
  end
endmodule

// File: rtl/pls_shift_lane.sv
module pls_shift_lane #(
  parameter int SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [SLOTS-1:0] d,
  output logic             q
);
  logic [SLOTS-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh <= '0;
    else if (clr)  sh <= '0;
    else if (load) sh <= d;
    else           sh <= {1'b0, sh[SLOTS-1:1]};
  end

  assign q = sh[0];

  // R2: slot 0 of a loaded word is on the lane right after the load edge
  p_load_slot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (q == $past(d[0])));

  // R9: clear empties the lane
  p_clr_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q);
endmodule

// File: rtl/pls_slot_tracker.sv
module pls_slot_tracker
  import pls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  output logic             word_live,
  output logic [CNT_W-1:0] slot_idx
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_live <= 1'b0;
      slot_idx  <= '0;
    end else if (clr) begin
      word_live <= 1'b0;
      slot_idx  <= '0;
    end else if (load) begin
      word_live <= 1'b1;
      slot_idx  <= '0;
    end else if (word_live) begin
      if (slot_idx == LAST) begin
        word_live <= 1'b0;
        slot_idx  <= '0;
      end else begin
        slot_idx <= slot_idx + 1'b1;
      end
    end
  end

  // R2: slot position never passes the last slot
  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_live |-> (slot_idx <= LAST));

  // R8: the last slot without a new load ends the word
  p_word_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_live && slot_idx == LAST && !load) |=> !word_live);
endmodule

// File: rtl/pixel_lane_serializer.sv
module pixel_lane_serializer
  import pls_pkg::*;
#(
  parameter int N_GRP = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pix_stb,
  input  logic                   dual_en,
  input  logic                   pwr_dn,
  input  logic [N_GRP*PIX_W-1:0] pix_in,
  input  logic [CTL_W-1:0]       ctl_in,
  output logic [N_GRP*LANES-1:0] lane_q,
  output logic                   clk_lane
);
  localparam int N_LANES = N_GRP * LANES;

  logic             load_fire;
  logic             word_live;
  logic [CNT_W-1:0] slot_idx;
  logic [WORD_W-1:0] grp_word [N_GRP];

  assign load_fire = pix_stb & ~pwr_dn;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic grp_en;
    assign grp_en = (g == 0) ? 1'b1 : dual_en;

    pls_lane_mapper u_map (
      .grp_en (grp_en),
      .pix    (pix_in[g*PIX_W +: PIX_W]),
      .ctl    (ctl_in),
      .word   (grp_word[g])
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      pls_shift_lane #(.SLOTS(SLOTS)) u_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pwr_dn),
        .load  (load_fire),
        .d     (grp_word[g][l*SLOTS +: SLOTS]),
        .q     (lane_q[g*LANES + l])
      );
    end
  end

  pls_shift_lane #(.SLOTS(SLOTS)) u_clk_lane (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pwr_dn),
    .load  (load_fire),
    .d     (clk_pattern()),
    .q     (clk_lane)
  );

  pls_slot_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (pwr_dn),
    .load      (load_fire),
    .word_live (word_live),
    .slot_idx  (slot_idx)
  );

  // R8: with no live word every lane is idle
  p_idle_when_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !word_live |-> (lane_q == '0 && !clk_lane));

  // R9: power-down idles all outputs one edge later
  p_pwrdn_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (lane_q == '0 && !clk_lane));

  // R5: the clock lane is high on slot 0 of every word
  p_clk_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> clk_lane);

  // R5: the clock lane is low on the last slot
  p_clk_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_live && slot_idx == CNT_W'(SLOTS - 1)) |-> !clk_lane);

  if (N_GRP > 1) begin : g_dual_chk
    // R7: upper lanes stay low for a word loaded in single mode
    p_dual_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_fire && !dual_en) |=> (lane_q[N_LANES-1:LANES] == '0));
  end
endmodule

// File: tb/pixel_lane_serializer_tb.sv
`timescale 1ns/1ps
module pixel_lane_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_stb = 1'b0;
  logic        dual_en = 1'b0;
  logic        pwr_dn = 1'b0;
  logic [47:0] pix_in = '0;
  logic [2:0]  ctl_in = '0;
  logic [7:0]  lane_q;
  logic        clk_lane;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pixel_lane_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .dual_en(dual_en),
    .pwr_dn(pwr_dn), .pix_in(pix_in), .ctl_in(ctl_in),
    .lane_q(lane_q), .clk_lane(clk_lane)
  );

  // {dual, ctl{vs,hs,de}, pixB, pixA}
  localparam logic [51:0] VEC [6] = '{
    {1'b0, 3'b001, 24'h000000, 24'h010204},
    {1'b1, 3'b010, 24'h804020, 24'h80_40_20},
    {1'b1, 3'b100, 24'hAA55AA, 24'h55AA55},
    {1'b0, 3'b111, 24'hFFFFFF, 24'hFFFFFF},
    {1'b1, 3'b000, 24'h123456, 24'hFEDCBA},
    {1'b1, 3'b101, 24'hFFFFFF, 24'h000000}
  };

  // Expected bit from the requirement text (R3, R4)
  function automatic logic exp_bit(input logic [23:0] p, input logic [2:0] c,
                                   input int lane, input int slot);
    case (lane)
      0: return p[16 + slot];
      1: return p[8 + slot];
      2: return p[slot];
      default:
        case (slot)
          0: return p[23];
          1: return p[15];
          2: return p[7];
          3: return c[0];
          4: return c[1];
          5: return c[2];
          default: return 1'b0;
        endcase
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Called at a negedge; loads a word and checks all seven slots.
  task automatic run_word(input logic [23:0] pa, input logic [23:0] pb,
                          input logic [2:0] c, input logic dual);
    logic [8:0]  gs [7];
    logic [27:0] ga, ea, gb, eb;
    logic [6:0]  gc, ec;
    pix_in  = {pb, pa};
    ctl_in  = c;
    dual_en = dual;
    pix_stb = 1'b1;
    for (int s = 0; s < 7; s++) begin
      tick();
      if (s == 0) pix_stb = 1'b0;
      gs[s] = {clk_lane, lane_q};
    end
    for (int s = 0; s < 7; s++) begin
      for (int l = 0; l < 4; l++) begin
        ga[l*7 + s] = gs[s][l];
        gb[l*7 + s] = gs[s][4 + l];
        ea[l*7 + s] = exp_bit(pa, c, l, s);
        eb[l*7 + s] = dual ? exp_bit(pb, c, l, s) : 1'b0;
      end
      gc[s] = gs[s][8];
      ec[s] = (s < 4);
    end
    check("R2", {gs[0][0], gs[6][0]}, {exp_bit(pa, c, 0, 0), exp_bit(pa, c, 0, 6)});
    check("R3", 64'(ga[20:0]), 64'(ea[20:0]));
    check("R4", 64'(ga[27:21]), 64'(ea[27:21]));
    check("R5", 64'(gc), 64'(ec));
    if (dual) check("R6", 64'(gb), 64'(eb));
    else      check("R7", 64'(gb), 64'(eb));
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] pa;
    logic [23:0] pb;
    repeat (3) @(negedge clk);
    check("R1", {clk_lane, lane_q}, 9'h0);
    rst_n = 1'b1;
    tick();
    tick();
    check("R1", {clk_lane, lane_q}, 9'h0);

    // Table of words, back to back
    for (int i = 0; i < 6; i++) begin
      run_word(VEC[i][23:0], VEC[i][47:24], VEC[i][50:48], VEC[i][51]);
    end

    // R8: seventh edge after the last load with no strobe
    tick();
    check("R8", {clk_lane, lane_q}, 9'h0);
    tick();
    check("R8", {clk_lane, lane_q}, 9'h0);

    // R10: strobe in the middle of a word restarts at slot 0
    pix_in = {24'h000000, 24'h00FF00};
    ctl_in = 3'b000;
    dual_en = 1'b0;
    pix_stb = 1'b1;
    tick();
    pix_stb = 1'b0;
    tick();
    tick();
    pa = 24'h7F007F;
    pix_in = {24'h000000, pa};
    ctl_in = 3'b001;
    pix_stb = 1'b1;
    tick();
    pix_stb = 1'b0;
    check("R10", {clk_lane, lane_q[3:0]},
          {1'b1, exp_bit(pa, 3'b001, 3, 0), exp_bit(pa, 3'b001, 2, 0),
           exp_bit(pa, 3'b001, 1, 0), exp_bit(pa, 3'b001, 0, 0)});
    repeat (6) tick();

    // R9: power-down in mid word, strobe during power-down ignored
    pa = 24'hFFFFFF;
    pb = 24'hFFFFFF;
    pix_in = {pb, pa};
    ctl_in = 3'b111;
    dual_en = 1'b1;
    pix_stb = 1'b1;
    tick();
    pix_stb = 1'b0;
    tick();
    pwr_dn = 1'b1;
    tick();
    check("R9", {clk_lane, lane_q}, 9'h0);
    pix_stb = 1'b1;
    tick();
    check("R9", {clk_lane, lane_q}, 9'h0);
    pwr_dn = 1'b0;
    pix_stb = 1'b0;
    tick();
    check("R9", {clk_lane, lane_q}, 9'h0);

    // Recovery after power-down
    run_word(24'hC3A50F, 24'h0F5AC3, 3'b110, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule